// File: doc/BRIEF.md
# Compare and Read-Modify-Write Execution Unit

This unit is one execution slice of a small 8-bit processor. In a single transaction it receives a decoded opcode, the register values, the operand byte already read from memory, the byte addressed by X, and the processor status byte. One clock later it returns the write-back strobes and data for the accumulator and for memory, the updated status byte, the instruction's cycle count, and an illegal-opcode indication.

The unit covers five groups of operations:

- compares against the accumulator, X or Y;
- one's complement of a memory byte;
- decrement of the accumulator or of memory;
- clearing one selected bit of the accumulator or of memory;
- clearing a single status flag.

When the T status bit is set, the accumulator compare becomes a memory-to-memory compare that uses the byte addressed by X as its minuend. Address generation and bus sequencing are handled elsewhere. The cycle count is only reported, so that the sequencer can use it.

Status byte layout, used on both `psw_in` and `psw_out`: bit 7 = N, bit 6 = V, bit 5 = T, bit 3 = D, bit 2 = I, bit 1 = Z, bit 0 = C. Bit 4 is passed through unchanged.

Top module: `cru_exec_unit`

## Requirements
- R1: The results of a transaction sampled with `in_valid`=1 appear on the outputs after the next rising edge, with `out_valid`=1. In any cycle that follows a clock where `in_valid`=0, or during reset, `out_valid`, `acc_we`, `mem_we` and `illegal` are 0.
- R2: Accumulator compare uses opcode 0xC9 or 0xC5. With T=0 it computes A − M; with T=1 it computes M(X) − M. It sets C=1 when the minuend is greater than or equal to the subtrahend (unsigned), Z=1 when the 8-bit difference is zero, and N to bit 7 of the difference. All other status bits are unchanged and nothing is written back.
- R3: Compare with X (0xE0, 0xE4) computes X − M, and compare with Y (0xC0, 0xC4) computes Y − M. Both ignore T, set C, Z and N as in R2, and write nothing back.
- R4: Opcode 0x44 writes ~M to memory (`mem_we`=1) and sets N and Z from the result. C and V are unchanged.
- R5: Opcode 0x1A writes A−1 to the accumulator, and opcode 0xC6 writes M−1 to memory. Both wrap 0x00 to 0xFF and set N and Z from the result, leaving C and V unchanged.
- R6: Opcodes whose low five bits are 0x1B clear bit i = opcode[7:5] of the accumulator. Opcodes whose low five bits are 0x1F clear bit i of memory. All other bits of the byte are kept, and the status byte is unchanged.
- R7: Each flag-clear opcode clears exactly one status bit and leaves the rest unchanged: 0x18 clears C, 0xD8 clears D, 0x58 clears I, 0x12 clears T, 0xB8 clears V. None of them writes back.
- R8: `cycles` reports the cycle count for each opcode:
  - 2 for 0xC9, 0xE0, 0xC0 and 0x58;
  - 3 for 0xC5, 0xE4 and 0xC4;
  - 5 for 0x44, 0xC6 and memory bit-clear;
  - 1 for 0x1A, accumulator bit-clear, 0x18, 0xD8, 0x12 and 0xB8.
- R9: Any other opcode sets `illegal`=1 and `cycles`=0, raises no write strobe, and returns `psw_out` equal to `psw_in`.
- R10: At most one of `acc_we` and `mem_we` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Transaction present on the inputs |
| opcode | input | 8 | Instruction opcode |
| acc_in | input | 8 | Accumulator value |
| x_in | input | 8 | X register value |
| y_in | input | 8 | Y register value |
| mem_in | input | 8 | Fetched memory operand M |
| memx_in | input | 8 | Memory byte addressed by X, M(X) |
| psw_in | input | 8 | Current status byte |
| out_valid | output | 1 | Result valid |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | Accumulator write data |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| psw_out | output | 8 | Updated status byte |
| cycles | output | 3 | Cycle count of the instruction |
| illegal | output | 1 | Opcode not recognised |

## Verification
Compares are driven with minuends below, equal to and above the subtrahend, so that carry, zero and negative each appear on their own. The accumulator compare is repeated with T set and the accumulator and M(X) chosen to disagree, which shows which byte was used; the X and Y compares are run with T set to show that T is ignored there. Decrement is tried at 0x00, 0x01 and 0x80 to expose wrap, zero and sign. Bit clear is swept over all eight indices on both targets, with an all-ones operand so that a wrong bit shows. Flag clears start from an all-ones status byte, and several unlisted opcodes, including neighbours of listed ones, probe the illegal path.

// File: rtl/cru_pkg.sv
package cru_pkg;
    localparam int FLG_N = 7;
    localparam int FLG_V = 6;
    localparam int FLG_T = 5;
    localparam int FLG_D = 3;
    localparam int FLG_I = 2;
    localparam int FLG_Z = 1;
    localparam int FLG_C = 0;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_CMP,
        OPK_CPX,
        OPK_CPY,
        OPK_COM,
        OPK_DEC,
        OPK_BCLR,
        OPK_FCLR
    } opk_e;

    typedef struct packed {
        opk_e       kind;
        logic       to_mem;
        logic [2:0] bidx;
        logic [2:0] cyc;
        logic [7:0] fclr;
    } dec_t;
endpackage

// File: rtl/cru_decode.sv
module cru_decode
    import cru_pkg::*;
(
    input  logic [7:0] opc,
    output dec_t       dec
);
    always_comb begin
        dec        = '0;
        dec.kind   = OPK_NONE;
        dec.bidx   = opc[7:5];
        case (opc)
            8'hC9: begin dec.kind = OPK_CMP; dec.cyc = 3'd2; end
            8'hC5: begin dec.kind = OPK_CMP; dec.cyc = 3'd3; end
            8'hE0: begin dec.kind = OPK_CPX; dec.cyc = 3'd2; end
            8'hE4: begin dec.kind = OPK_CPX; dec.cyc = 3'd3; end
            8'hC0: begin dec.kind = OPK_CPY; dec.cyc = 3'd2; end
            8'hC4: begin dec.kind = OPK_CPY; dec.cyc = 3'd3; end
            8'h44: begin dec.kind = OPK_COM; dec.to_mem = 1'b1; dec.cyc = 3'd5; end
            8'h1A: begin dec.kind = OPK_DEC; dec.cyc = 3'd1; end
            8'hC6: begin dec.kind = OPK_DEC; dec.to_mem = 1'b1; dec.cyc = 3'd5; end
            8'h18: begin dec.kind = OPK_FCLR; dec.fclr[FLG_C] = 1'b1; dec.cyc = 3'd1; end
            8'hD8: begin dec.kind = OPK_FCLR; dec.fclr[FLG_D] = 1'b1; dec.cyc = 3'd1; end
            8'h58: begin dec.kind = OPK_FCLR; dec.fclr[FLG_I] = 1'b1; dec.cyc = 3'd2; end
            8'h12: begin dec.kind = OPK_FCLR; dec.fclr[FLG_T] = 1'b1; dec.cyc = 3'd1; end
            8'hB8: begin dec.kind = OPK_FCLR; dec.fclr[FLG_V] = 1'b1; dec.cyc = 3'd1; end
            default: begin
                if (opc[4:0] == 5'h1B) begin
                    dec.kind = OPK_BCLR;
                    dec.cyc  = 3'd1;
                end else if (opc[4:0] == 5'h1F) begin
                    dec.kind   = OPK_BCLR;
                    dec.to_mem = 1'b1;
                    dec.cyc    = 3'd5;
                end
            end
        endcase
    end
endmodule

// File: rtl/cru_compare.sv
module cru_compare #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] minuend,
    input  logic [DW-1:0] subtrahend,
    output logic          c_out,
    output logic          z_out,
    output logic          n_out
);
    localparam int XW = DW + 1;

    logic [XW-1:0] diff;

    always_comb begin
        diff  = {1'b0, minuend} - {1'b0, subtrahend};
        c_out = ~diff[XW-1];
        z_out = (diff[DW-1:0] == '0);
        n_out = diff[DW-1];
    end
endmodule

// File: rtl/cru_modify.sv
module cru_modify
    import cru_pkg::*;
#(
    parameter int DW = 8
) (
    input  opk_e          kind,
    input  logic [DW-1:0] operand,
    input  logic [2:0]    bidx,
    output logic [DW-1:0] result,
    output logic          n_out,
    output logic          z_out
);
    logic [DW-1:0] keep_mask;

    for (genvar b = 0; b < DW; b++) begin : g_mask
        assign keep_mask[b] = (int'(bidx) != b);
    end

    always_comb begin
        case (kind)
            OPK_COM:  result = ~operand;
            OPK_DEC:  result = operand - {{(DW-1){1'b0}}, 1'b1};
            OPK_BCLR: result = operand & keep_mask;
            default:  result = operand;
        endcase
        n_out = result[DW-1];
        z_out = (result == '0);
    end
endmodule

// File: rtl/cru_exec_unit.sv
module cru_exec_unit
    import cru_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] mem_in,
    input  logic [DW-1:0] memx_in,
    input  logic [7:0]    psw_in,
    output logic          out_valid,
    output logic          acc_we,
    output logic [DW-1:0] acc_wdata,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [7:0]    psw_out,
    output logic [2:0]    cycles,
    output logic          illegal
);
    typedef struct packed {
        logic          vld;
        logic          awe;
        logic [DW-1:0] awd;
        logic          mwe;
        logic [DW-1:0] mwd;
        logic [7:0]    psw;
        logic [2:0]    cyc;
        logic          ill;
    } res_t;

    dec_t          dec;
    logic [DW-1:0] cmp_min;
    logic          cmp_c, cmp_z, cmp_n;
    logic [DW-1:0] mod_src, mod_res;
    logic          mod_n, mod_z;
    res_t          st_d, st_q;

    cru_decode u_dec (
        .opc (opcode),
        .dec (dec)
    );

    // minuend select: T mode only redirects the accumulator compare
    always_comb begin
        case (dec.kind)
            OPK_CPX: cmp_min = x_in;
            OPK_CPY: cmp_min = y_in;
            default: cmp_min = psw_in[FLG_T] ? memx_in : acc_in;
        endcase
        mod_src = dec.to_mem ? mem_in : acc_in;
    end

    cru_compare #(.DW(DW)) u_cmp (
        .minuend    (cmp_min),
        .subtrahend (mem_in),
        .c_out      (cmp_c),
        .z_out      (cmp_z),
        .n_out      (cmp_n)
    );

    cru_modify #(.DW(DW)) u_mod (
        .kind    (dec.kind),
        .operand (mod_src),
        .bidx    (dec.bidx),
        .result  (mod_res),
        .n_out   (mod_n),
        .z_out   (mod_z)
    );

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.vld = 1'b1;
            st_d.psw = psw_in;
            st_d.cyc = dec.cyc;
            case (dec.kind)
                OPK_CMP, OPK_CPX, OPK_CPY: begin
                    st_d.psw[FLG_C] = cmp_c;
                    st_d.psw[FLG_Z] = cmp_z;
                    st_d.psw[FLG_N] = cmp_n;
                end
                OPK_COM, OPK_DEC: begin
                    st_d.psw[FLG_Z] = mod_z;
                    st_d.psw[FLG_N] = mod_n;
                    st_d.awe = ~dec.to_mem;
                    st_d.mwe = dec.to_mem;
                end
                OPK_BCLR: begin
                    st_d.awe = ~dec.to_mem;
                    st_d.mwe = dec.to_mem;
                end
                OPK_FCLR: begin
                    st_d.psw = psw_in & ~dec.fclr;
                end
                default: begin
                    st_d.ill = 1'b1;
                end
            endcase
            st_d.awd = st_d.awe ? mod_res : '0;
            st_d.mwd = st_d.mwe ? mod_res : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign acc_we    = st_q.awe;
    assign acc_wdata = st_q.awd;
    assign mem_we    = st_q.mwe;
    assign mem_wdata = st_q.mwd;
    assign psw_out   = st_q.psw;
    assign cycles    = st_q.cyc;
    assign illegal   = st_q.ill;
endmodule

// File: rtl/cru_exec_unit_chk.sv
module cru_exec_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] opcode,
    input logic [7:0] x_in,
    input logic [7:0] mem_in,
    input logic [7:0] psw_in,
    input logic       out_valid,
    input logic       acc_we,
    input logic       mem_we,
    input logic [7:0] psw_out,
    input logic [2:0] cycles,
    input logic       illegal
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!acc_we && !mem_we && !illegal));

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_we, mem_we}));

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!acc_we && !mem_we && cycles == 3'd0 && psw_out == $past(psw_in)));

    // R3
    cpx_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode) == 8'hE0) |-> (psw_out[0] == ($past(x_in) >= $past(mem_in))));

    // R6
    bclr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(opcode[4:0]) == 5'h1B) |-> (psw_out == $past(psw_in)));
endmodule

bind cru_exec_unit cru_exec_unit_chk u_chk (.*);

// File: tb/sim_cru_exec_unit.sv
`timescale 1ns/1ps
module sim_cru_exec_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] opcode = '0, acc_in = '0, x_in = '0, y_in = '0;
    logic [7:0] mem_in = '0, memx_in = '0, psw_in = '0;
    logic       out_valid, acc_we, mem_we, illegal;
    logic [7:0] acc_wdata, mem_wdata, psw_out;
    logic [2:0] cycles;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic       awe;
        logic [7:0] awd;
        logic       mwe;
        logic [7:0] mwd;
        logic [7:0] psw;
        logic [2:0] cyc;
        logic       ill;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    cru_exec_unit u0 (.*);

    function automatic exp_t model(input logic [7:0] o, a, x, y, m, mx, p, input string tag);
        exp_t e;
        logic [8:0] d;
        logic [7:0] mn;
        logic [7:0] r;
        bit cmp = 1'b0;
        bit rmw = 1'b0;
        e = '{awe: 1'b0, awd: 8'h00, mwe: 1'b0, mwd: 8'h00, psw: p, cyc: 3'd0, ill: 1'b0, tag: tag};
        mn = 8'h00;
        r = 8'h00;
        case (o)
            8'hC9, 8'hC5: begin cmp = 1'b1; mn = p[5] ? mx : a; e.cyc = (o == 8'hC9) ? 3'd2 : 3'd3; end
            8'hE0, 8'hE4: begin cmp = 1'b1; mn = x; e.cyc = (o == 8'hE0) ? 3'd2 : 3'd3; end
            8'hC0, 8'hC4: begin cmp = 1'b1; mn = y; e.cyc = (o == 8'hC0) ? 3'd2 : 3'd3; end
            8'h44: begin rmw = 1'b1; r = ~m; e.mwe = 1'b1; e.cyc = 3'd5; end
            8'h1A: begin rmw = 1'b1; r = a - 8'd1; e.awe = 1'b1; e.cyc = 3'd1; end
            8'hC6: begin rmw = 1'b1; r = m - 8'd1; e.mwe = 1'b1; e.cyc = 3'd5; end
            8'h18: begin e.psw[0] = 1'b0; e.cyc = 3'd1; end
            8'hD8: begin e.psw[3] = 1'b0; e.cyc = 3'd1; end
            8'h58: begin e.psw[2] = 1'b0; e.cyc = 3'd2; end
            8'h12: begin e.psw[5] = 1'b0; e.cyc = 3'd1; end
            8'hB8: begin e.psw[6] = 1'b0; e.cyc = 3'd1; end
            default: begin
                if (o[4:0] == 5'h1B) begin
                    e.awe = 1'b1; e.awd = a; e.awd[o[7:5]] = 1'b0; e.cyc = 3'd1;
                end else if (o[4:0] == 5'h1F) begin
                    e.mwe = 1'b1; e.mwd = m; e.mwd[o[7:5]] = 1'b0; e.cyc = 3'd5;
                end else begin
                    e.ill = 1'b1;
                end
            end
        endcase
        if (cmp) begin
            d = {1'b0, mn} - {1'b0, m};
            e.psw[0] = (mn >= m);
            e.psw[1] = (d[7:0] == 8'h00);
            e.psw[7] = d[7];
        end
        if (rmw) begin
            e.psw[1] = (r == 8'h00);
            e.psw[7] = r[7];
            if (e.awe) e.awd = r;
            if (e.mwe) e.mwd = r;
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] o, a, x, y, m, mx, p, input string tag);
        sb.push_back(model(o, a, x, y, m, mx, p, tag));
        opcode = o; acc_in = a; x_in = x; y_in = y;
        mem_in = m; memx_in = mx; psw_in = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard when a result appears
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                exp_t e;
                if (sb.size() == 0) begin
                    chk(1'b0, "R1", "unexpected out_valid", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(acc_we == e.awe, e.tag, "acc_we", acc_we, e.awe);
                    if (e.awe) chk(acc_wdata == e.awd, e.tag, "acc_wdata", acc_wdata, e.awd);
                    chk(mem_we == e.mwe, e.tag, "mem_we", mem_we, e.mwe);
                    if (e.mwe) chk(mem_wdata == e.mwd, e.tag, "mem_wdata", mem_wdata, e.mwd);
                    chk(psw_out == e.psw, e.tag, "psw_out", psw_out, e.psw);
                    chk(cycles == e.cyc, "R8", "cycles", cycles, e.cyc);
                    chk(illegal == e.ill, e.tag, "illegal", illegal, e.ill);
                end
            end else if (rst_n) begin
                chk(!acc_we && !mem_we && !illegal, "R1", "idle strobes", {acc_we, mem_we, illegal}, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!out_valid && !acc_we && !mem_we && !illegal && psw_out == 8'h00, "R1", "reset outputs",
            {out_valid, acc_we, mem_we, illegal}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 accumulator compare, T=0: below, equal, above
        issue(8'hC9, 8'h10, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, "R2");
        issue(8'hC5, 8'h55, 8'h00, 8'h00, 8'h55, 8'h00, 8'h40, "R2");
        issue(8'hC9, 8'hF0, 8'h00, 8'h00, 8'h01, 8'h00, 8'h0C, "R2");
        // R2 T=1: accumulator and M(X) disagree
        issue(8'hC9, 8'h00, 8'h00, 8'h00, 8'h30, 8'h30, 8'h20, "R2");
        issue(8'hC5, 8'hFF, 8'h00, 8'h00, 8'h40, 8'h10, 8'h20, "R2");
        // R3 X and Y compares, T set is ignored
        issue(8'hE0, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00, 8'h20, "R3");
        issue(8'hE4, 8'h00, 8'h01, 8'h00, 8'h02, 8'hFF, 8'h00, "R3");
        issue(8'hC0, 8'h00, 8'h00, 8'h7F, 8'h00, 8'h00, 8'h20, "R3");
        issue(8'hC4, 8'hAA, 8'h00, 8'h10, 8'hAA, 8'hAA, 8'hC1, "R3");
        // R4 complement
        issue(8'h44, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h41, "R4");
        issue(8'h44, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h80, "R4");
        // R5 decrement wrap, zero, sign
        issue(8'h1A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h41, "R5");
        issue(8'h1A, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, "R5");
        issue(8'hC6, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'h03, "R5");
        // R6 bit clear over every index, both targets
        for (int i = 0; i < 8; i++) begin
            issue(8'(8'h1B + 8'(i * 32)), 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hE3, "R6");
            issue(8'(8'h1F + 8'(i * 32)), 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h1C, "R6");
        end
        // R7 flag clears from all ones
        issue(8'h18, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, "R7");
        issue(8'hD8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, "R7");
        issue(8'h58, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, "R7");
        issue(8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, "R7");
        issue(8'hB8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, "R7");
        // R9 unlisted opcodes, including neighbours of listed ones
        issue(8'h00, 8'h12, 8'h00, 8'h00, 8'h34, 8'h00, 8'h5A, "R9");
        issue(8'hC8, 8'h12, 8'h00, 8'h00, 8'h34, 8'h00, 8'hA5, "R9");
        issue(8'h1C, 8'h12, 8'h00, 8'h00, 8'h34, 8'h00, 8'hFF, "R9");
        issue(8'h45, 8'h12, 8'h00, 8'h00, 8'h34, 8'h00, 8'h00, "R9");
        // R10 is covered by every strobe check above; drain the pipe
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R1", "results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule